// File: doc/BRIEF.md
# Interrupt-Sensing GPIO Port

A 32-pin general-purpose I/O port behind a small synchronous register bus. Software writes an output value and a per-pin direction, reads back the state of the pads, and picks for every pin how it raises an interrupt event. The choices are low level, high level, rising edge or falling edge. A per-pin any-edge select bit overrides that choice.

Pad inputs are resynchronized into the port's clock domain before any detection. A detected event latches a per-pin status bit. Software clears it by writing a one to that bit. A mask word selects which status bits drive the single registered interrupt line. The bus has no handshake. A write takes effect at the clock edge that samples it, and read data follows the address in the same cycle.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, every register reads zero, and `pad_out`, `pad_oe` and `irq` are zero.
- R2: The output word (byte address 0x00) reads back what was written, and `pad_out[n]` equals its bit n.
- R3: The direction word (0x04) reads back what was written, and `pad_oe[n]` equals its bit n, where 1 means output.
- R4: The pad-state word (0x08) returns `pad_in` after a two-flop synchronizer, valid no later than three clock edges after a change. Writes to 0x08 change nothing.
- R5: The sense code of pins 0 to 15 sits in the word at 0x0C, and that of pins 16 to 31 in the word at 0x10. Pin n uses bits [2(n mod 16)+1 : 2(n mod 16)]. Both words read back as written.
- R6: Sense codes are 0 for low level, 1 for high level, 2 for rising edge and 3 for falling edge. A detected event sets bit n of the status word (0x18).
- R7: When bit n of the any-edge word (0x1C) is 1, pin n flags both rising and falling edges and ignores its sense code. The word reads back as written.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: A level-sensed status bit whose level is still present remains set after a clearing write.
- R10: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R11: `irq` is the registered OR of status AND mask (mask word at 0x14). It follows a change of either within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| bus_addr | input | 5 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Interrupt request |

## Verification
The sense logic is swept with two pad words per configuration: a settling word, then a clear, then a second word. Each pin sees a 0-to-0, 0-to-1, 1-to-0 and 1-to-1 transition across the bit positions. This separates level from edge sensing and rising from falling, and shows whether a level-sensed bit survives its clear. The sweeps use uniform codes for each of the four values, a mixed per-pin code pattern that spans both configuration words, and full and partial any-edge overrides. These show whether a pin reads its field from the right word and position and whether the override wins. Further directed cases cover a clearing write timed onto the exact event cycle, partial and zero clears, and mask changes with the status held still.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
   localparam int BUS_W  = 32;
   localparam int ADDR_W = 5;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'd0,
      SENSE_HIGH = 2'd1,
      SENSE_RISE = 2'd2,
      SENSE_FALL = 2'd3
   } sense_e;

   // word index = byte address / 4
   localparam logic [2:0] IDX_OUT   = 3'd0;
   localparam logic [2:0] IDX_DIR   = 3'd1;
   localparam logic [2:0] IDX_PAD   = 3'd2;
   localparam logic [2:0] IDX_CFGL  = 3'd3;
   localparam logic [2:0] IDX_CFGH  = 3'd4;
   localparam logic [2:0] IDX_MASK  = 3'd5;
   localparam logic [2:0] IDX_STAT  = 3'd6;
   localparam logic [2:0] IDX_ANYE  = 3'd7;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pad,
   output logic [W-1:0] lvl,
   output logic [W-1:0] lvl_d
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= pad;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= '0;
      else        lvl_d <= stg[STAGES-1];
   end

   assign lvl = stg[STAGES-1];
endmodule

// File: rtl/gpio_sense_cell.sv
`timescale 1ns/1ps
module gpio_sense_cell
   import gpio_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  logic       lvl_d,
   input  logic [1:0] code,
   input  logic       any_edge,
   input  logic       clr,
   output logic       stat
);
   logic evt;

   always_comb begin
      if (any_edge) begin
         evt = lvl ^ lvl_d;
      end else begin
         unique case (code)
            SENSE_LOW:  evt = ~lvl;
            SENSE_HIGH: evt = lvl;
            SENSE_RISE: evt = lvl & ~lvl_d;
            default:    evt = ~lvl & lvl_d;
         endcase
      end
   end

   // event has priority over a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= 1'b0;
      else        stat <= evt | (stat & ~clr);
   end

   // R10
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && clr) |=> stat);

   // R8
   clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat) |-> $past(clr));

   // R9
   level_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_edge && code == SENSE_LOW && !lvl) |=> stat);

   // R7
   any_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_edge && (lvl != lvl_d)) |=> stat);
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic              irq
);
   localparam int FIELDS = BUS_W / 2;   // sense fields per config word

   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
      $error("gpio_irq_port: NPINS must be 1..32");
   end

   logic [2:0]       widx;
   logic [NPINS-1:0] out_q, dir_q, mask_q, anye_q, stat;
   logic [BUS_W-1:0] cfgl_q, cfgh_q;
   logic [NPINS-1:0] lvl, lvl_d, clr;
   logic             irq_q;

   assign widx = bus_addr[4:2];
   assign clr  = (bus_we && widx == IDX_STAT) ? bus_wdata[NPINS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         mask_q <= '0;
         anye_q <= '0;
         cfgl_q <= '0;
         cfgh_q <= '0;
      end else if (bus_we) begin
         unique case (widx)
            IDX_OUT:  out_q  <= bus_wdata[NPINS-1:0];
            IDX_DIR:  dir_q  <= bus_wdata[NPINS-1:0];
            IDX_CFGL: cfgl_q <= bus_wdata;
            IDX_CFGH: cfgh_q <= bus_wdata;
            IDX_MASK: mask_q <= bus_wdata[NPINS-1:0];
            IDX_ANYE: anye_q <= bus_wdata[NPINS-1:0];
            default:  ;
         endcase
      end
   end

   gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pad   (pad_in),
      .lvl   (lvl),
      .lvl_d (lvl_d)
   );

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic [1:0] code;
      if (p < FIELDS) begin : g_lo
         assign code = cfgl_q[2*p +: 2];
      end else begin : g_hi
         assign code = cfgh_q[2*(p-FIELDS) +: 2];
      end
      gpio_sense_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl      (lvl[p]),
         .lvl_d    (lvl_d[p]),
         .code     (code),
         .any_edge (anye_q[p]),
         .clr      (clr[p]),
         .stat     (stat[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(stat & mask_q);
   end

   always_comb begin
      bus_rdata = '0;
      unique case (widx)
         IDX_OUT:  bus_rdata[NPINS-1:0] = out_q;
         IDX_DIR:  bus_rdata[NPINS-1:0] = dir_q;
         IDX_PAD:  bus_rdata[NPINS-1:0] = lvl;
         IDX_CFGL: bus_rdata            = cfgl_q;
         IDX_CFGH: bus_rdata            = cfgh_q;
         IDX_MASK: bus_rdata[NPINS-1:0] = mask_q;
         IDX_STAT: bus_rdata[NPINS-1:0] = stat;
         default:  bus_rdata[NPINS-1:0] = anye_q;
      endcase
   end

   assign pad_out = out_q;
   assign pad_oe  = dir_q;
   assign irq     = irq_q;

   // R11
   irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|(stat & mask_q)));

   // R11
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat & mask_q)) |=> irq);

   // R3
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && widx == IDX_DIR) |=> (pad_oe == $past(bus_wdata[NPINS-1:0])));

   // R2
   out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && widx == IDX_OUT) |=> (pad_out == $past(bus_wdata[NPINS-1:0])));
endmodule

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    addr = '0;
   logic          we = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [N-1:0]  pin = '0;
   logic [N-1:0]  pout, poe;
   logic          irq;
   int            checks = 0;
   int            errors = 0;

   always #2.5 clk = ~clk;

   gpio_irq_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pin),
      .pad_out(pout), .pad_oe(poe), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; we = 1'b1; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [1:0] code_of(input int n, input logic [31:0] lo, input logic [31:0] hi);
      return (n < 16) ? lo[2*n +: 2] : hi[2*(n-16) +: 2];
   endfunction

   function automatic logic lvl_hit(input logic [1:0] c, input logic e, input logic v);
      return !e && ((c == 2'd0 && !v) || (c == 2'd1 && v));
   endfunction

   function automatic logic edge_hit(input logic [1:0] c, input logic e, input logic a, input logic b);
      if (e) return a ^ b;
      return (c == 2'd2 && !a && b) || (c == 2'd3 && a && !b);
   endfunction

   // settle on A, clear all, check; move to B, check accumulated status
   task automatic sweep(input string req, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [31:0] anye, input logic [31:0] a, input logic [31:0] b);
      logic [31:0] e1, e2, r;
      wr(5'h0C, lo); wr(5'h10, hi); wr(5'h1C, anye);
      @(negedge clk); pin = a;
      idle(5);
      wr(5'h18, 32'hFFFF_FFFF);
      for (int n = 0; n < N; n++) begin
         e1[n] = lvl_hit(code_of(n, lo, hi), anye[n], a[n]);
         e2[n] = e1[n] | lvl_hit(code_of(n, lo, hi), anye[n], b[n])
                       | edge_hit(code_of(n, lo, hi), anye[n], a[n], b[n]);
      end
      rd(5'h18, r); check({req, " after clear"}, r, e1);
      @(negedge clk); pin = b;
      idle(5);
      rd(5'h18, r); check({req, " after change"}, r, e2);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] r, lo, hi;
      // R1 reset values
      idle(2);
      for (int i = 0; i < 8; i++) begin
         rd(5'(i*4), r); check("R1 reset register", r, 32'h0);
      end
      check("R1 reset pad_out", pout, 32'h0);
      check("R1 reset pad_oe", poe, 32'h0);
      check("R1 reset irq", {31'h0, irq}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      // R2 / R3
      foreach (lo[i]) lo[i] = 1'b0;
      for (int k = 0; k < 4; k++) begin
         logic [31:0] pat;
         pat = (k == 0) ? 32'hA5A5_5A5A : (k == 1) ? 32'hFFFF_0000 :
               (k == 2) ? 32'h0000_0001 : 32'h8000_0000;
         wr(5'h00, pat); rd(5'h00, r);
         check("R2 out readback", r, pat); check("R2 pad_out", pout, pat);
         wr(5'h04, ~pat); rd(5'h04, r);
         check("R3 dir readback", r, ~pat); check("R3 pad_oe", poe, ~pat);
      end

      // R4 pad-state and write ignore
      @(negedge clk); pin = 32'hDEAD_BEEF;
      idle(3);
      rd(5'h08, r); check("R4 pad state", r, 32'hDEAD_BEEF);
      wr(5'h08, 32'h1234_5678);
      rd(5'h08, r); check("R4 pad write ignored", r, 32'hDEAD_BEEF);

      // R6 uniform code sweeps, R9 level pins keep their bit
      for (int c = 0; c < 4; c++) begin
         lo = {16{2'(c)}};
         sweep(c < 2 ? "R6 R9 uniform level" : "R6 uniform edge",
               lo, lo, 32'h0, 32'h0F0F_33CC, 32'h00FF_5A5A);
      end
      // R5 mixed per-pin codes spanning both words
      for (int n = 0; n < 16; n++) begin
         lo[2*n +: 2] = 2'((n * 3 + 1) % 4);
         hi[2*n +: 2] = 2'((n * 5 + 2) % 4);
      end
      wr(5'h0C, lo); rd(5'h0C, r); check("R5 cfg low readback", r, lo);
      wr(5'h10, hi); rd(5'h10, r); check("R5 cfg high readback", r, hi);
      sweep("R5 mixed codes", lo, hi, 32'h0, 32'h3C3C_C3C3, 32'h6699_9966);
      sweep("R5 mixed codes swapped", hi, lo, 32'h0, 32'h6699_9966, 32'h3C3C_C3C3);
      // R7 any-edge override
      wr(5'h1C, 32'hA5A5_0F0F); rd(5'h1C, r); check("R7 any-edge readback", r, 32'hA5A5_0F0F);
      sweep("R7 partial any-edge", lo, hi, 32'hA5A5_0F0F, 32'h0F0F_33CC, 32'h00FF_5A5A);
      sweep("R7 full any-edge", 32'h0, 32'h5555_5555, 32'hFFFF_FFFF, 32'hF0F0_1234, 32'h0FF0_4321);

      // R8 partial and zero clears on edge-sensed pins
      wr(5'h0C, 32'hAAAA_AAAA); wr(5'h10, 32'hAAAA_AAAA); wr(5'h1C, 32'h0);
      @(negedge clk); pin = 32'h0;
      idle(5); wr(5'h18, 32'hFFFF_FFFF);
      @(negedge clk); pin = 32'h00FF_F00F;
      idle(5);
      rd(5'h18, r); check("R8 set by rise", r, 32'h00FF_F00F);
      wr(5'h18, 32'h0);
      rd(5'h18, r); check("R8 zero write keeps", r, 32'h00FF_F00F);
      wr(5'h18, 32'h0F0F_0F0F);
      rd(5'h18, r); check("R8 partial clear", r, 32'h00F0_F000);

      // R11 mask and irq
      wr(5'h18, 32'hFFFF_FFFF);
      wr(5'h14, 32'h0);
      @(negedge clk); pin = 32'h0000_0100;
      idle(5);
      check("R11 masked off", {31'h0, irq}, 32'h0);
      wr(5'h14, 32'h0000_0001); idle(1);
      check("R11 mask on idle bit", {31'h0, irq}, 32'h0);
      wr(5'h14, 32'h0000_0100); idle(1);
      rd(5'h14, r); check("R11 mask readback", r, 32'h0000_0100);
      check("R11 irq asserted", {31'h0, irq}, 32'h1);
      wr(5'h18, 32'h0000_0100); idle(1);
      check("R11 irq after clear", {31'h0, irq}, 32'h0);

      // R10 clear lands on the event cycle
      @(negedge clk); pin[3] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); addr = 5'h18; we = 1'b1; wdata = 32'h0000_0008;
      @(negedge clk); we = 1'b0;
      rd(5'h18, r); check("R10 set beats clear", r & 32'h8, 32'h8);
      wr(5'h18, 32'h0000_0008);
      rd(5'h18, r); check("R10 later clear works", r & 32'h8, 32'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule